// File: doc/BRIEF.md
# One-Time-Programmable Byte Burn Sequencer

This controller writes a stream of bytes into a byte-wide one-time-programmable memory whose cells erase to all ones and can only be cleared to zero. A host hands it address/data pairs over a valid/ready request port, and marks the final byte of a batch with a last flag. For each byte the sequencer drives the address and data pins of the part. It asserts the data-bus output enable and applies a fixed-length write strobe on the active-low chip-enable, with the active-low output enable held high. It then releases the bus and reads the cell back, with chip-enable high and output enable low.

A byte that reads back correctly is finished at once; no extra pulse is applied. A byte that does not match is pulsed again, up to a parameterised budget (ten by default). If it still does not match after that, the byte fails and the batch is aborted. A target of all ones is already erased and is reported as passed without any pulse. Every byte ends in a one-cycle status report carrying its address, a pass flag and the 4-bit number of pulses used.

The programming-voltage supply is modelled as a single enable output. It is raised when a batch starts and dropped after the last byte or after a failure. The strobe length, setup and hold windows and read-back delay are all clock-count parameters. The default strobe is 10000 cycles, which is 100 microseconds at 100 MHz.

Top module: `otp_burn_seq`

## Requirements
- R1: While reset is asserted and directly after it: mem_ce_n=1, mem_oe_n=1, mem_dout_en=0, vpp_en=0, req_ready=1, sts_valid=0.
- R2: Each write strobe holds mem_ce_n low for exactly PULSE_CYC consecutive cycles, with mem_oe_n high, mem_dout_en high and vpp_en high throughout.
- R3: mem_addr and mem_dout are driven (mem_dout_en=1) and unchanged for at least SETUP_CYC cycles before mem_ce_n falls. They stay driven and unchanged for at least HOLD_CYC cycles after mem_ce_n rises.
- R4: Read-back uses mem_ce_n=1 with mem_oe_n=0 for READ_CYC cycles, sampling mem_din in the last of them. mem_dout_en is 0 in every cycle with mem_oe_n low and in the cycle before mem_oe_n falls.
- R5: A byte whose read-back equals the target after pulse k (k not above MAX_PULSES) is reported passed with sts_pulses=k. No further pulse is applied to it.
- R6: A byte that still mismatches after MAX_PULSES pulses is reported failed with sts_pulses=MAX_PULSES. A match found on the final allowed pulse is reported as a pass.
- R7: A target of all ones (8'hFF) is reported passed with sts_pulses=0, and mem_ce_n never falls for it.
- R8: Each byte yields exactly one cycle of sts_valid=1, with sts_addr equal to the byte's address, sts_pass (1=pass) and the 4-bit sts_pulses count.
- R9: vpp_en is 1 from the cycle after a request is accepted until its status cycle. After the status of a byte with req_last=1 or of a failed byte, vpp_en is 0; otherwise it stays 1 while req_ready waits for the next byte. req_ready is 0 while a byte is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ADDR_W | Byte address to program |
| req_data | input | DATA_W | Target byte value |
| req_last | input | 1 | Final byte of the batch |
| sts_valid | output | 1 | One-cycle status strobe |
| sts_addr | output | ADDR_W | Address of the reported byte |
| sts_pass | output | 1 | 1 = byte verified |
| sts_pulses | output | 4 | Strobes applied to the byte |
| mem_addr | output | ADDR_W | Address pins of the part |
| mem_dout | output | DATA_W | Data toward the part |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | DATA_W | Data read from the part |
| mem_ce_n | output | 1 | Active-low chip enable / write strobe |
| mem_oe_n | output | 1 | Active-low output enable of the part |
| vpp_en | output | 1 | Programming-voltage enable |

## Verification
The read-back decision on the last allowed pulse is the point where two outcomes meet in one cycle. The verify match and the exhaustion of the pulse budget are both true on the same clock edge, and the match must win. The bench provokes this by sweeping a memory model whose cells need from one to eleven strobes, so one byte passes on exactly the tenth pulse and another never passes. It judges the tenth-pulse byte as passed with count ten and the never-passing byte as failed with count ten and a dropped supply enable. The pin monitor times every strobe, setup, hold and bus release against the parameters during the same sweep.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;

  // Width of the reported pulse count
  localparam int unsigned CNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_REL,
    ST_VERIFY,
    ST_REPORT
  } burn_state_e;

endpackage

// File: rtl/otp_burn_timer.sv
module otp_burn_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/otp_burn_tally.sv
module otp_burn_tally #(
  parameter int unsigned W   = 4,
  parameter int unsigned MAX = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         incr,
  output logic [W-1:0] cnt,
  output logic         at_max
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = clear | incr;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (incr) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt    = cnt_q;
  assign at_max = (cnt_q == W'(MAX));

  // R6
  tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(MAX));

  // R6
  incr_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    incr |-> !at_max);

endmodule

// File: rtl/otp_burn_pins.sv
module otp_burn_pins
  import otp_burn_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  burn_state_e       state,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] data_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              vpp_en
);

  always_comb begin
    mem_addr    = addr_q;
    mem_dout    = data_q;
    mem_dout_en = 1'b0;
    mem_ce_n    = 1'b1;
    mem_oe_n    = 1'b1;
    vpp_en      = 1'b1;
    unique case (state)
      ST_IDLE:   vpp_en = 1'b0;
      ST_WAIT:   ;
      ST_SETUP:  mem_dout_en = 1'b1;
      ST_PULSE: begin
        mem_dout_en = 1'b1;
        mem_ce_n    = 1'b0;
      end
      ST_HOLD:   mem_dout_en = 1'b1;
      ST_REL:    ;
      ST_VERIFY: mem_oe_n = 1'b0;
      ST_REPORT: ;
      default:   vpp_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_burn_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PULSE_CYC  = 10000,
  parameter int unsigned SETUP_CYC  = 4,
  parameter int unsigned HOLD_CYC   = 4,
  parameter int unsigned READ_CYC   = 4,
  parameter int unsigned MAX_PULSES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_last,
  output logic              sts_valid,
  output logic [ADDR_W-1:0] sts_addr,
  output logic              sts_pass,
  output logic [CNT_W-1:0]  sts_pulses,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              vpp_en
);

  localparam int unsigned MAX_AB = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int unsigned MAX_CD = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
  localparam int unsigned MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned TW     = $clog2(MAXC + 1);
  localparam logic [TW-1:0] SETUP_V = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] PULSE_V = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] HOLD_V  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] READ_V  = TW'(READ_CYC - 1);

  burn_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              last_q;
  logic              pass_q, pass_d;
  logic              accept;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_done;
  logic              t_clear;
  logic              t_incr;
  logic [CNT_W-1:0]  t_cnt;
  logic              t_at_max;
  logic              read_match;

  otp_burn_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  otp_burn_tally #(.W(CNT_W), .MAX(MAX_PULSES)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (t_clear),
    .incr   (t_incr),
    .cnt    (t_cnt),
    .at_max (t_at_max)
  );

  otp_burn_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state       (state_q),
    .addr_q      (addr_q),
    .data_q      (data_q),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .vpp_en      (vpp_en)
  );

  assign req_ready  = (state_q == ST_IDLE) || (state_q == ST_WAIT);
  assign read_match = (mem_din == data_q);

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    pass_d   = pass_q;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    t_clear  = 1'b0;
    t_incr   = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_WAIT: begin
        if (req_valid) begin
          accept  = 1'b1;
          t_clear = 1'b1;
          if (req_data == '1) begin
            state_d = ST_REPORT;
            pass_d  = 1'b1;
          end else begin
            state_d  = ST_SETUP;
            tmr_load = 1'b1;
            tmr_val  = SETUP_V;
          end
        end
      end
      ST_SETUP: begin
        if (tmr_done) begin
          state_d  = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = PULSE_V;
          t_incr   = 1'b1;
        end
      end
      ST_PULSE: begin
        if (tmr_done) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_V;
        end
      end
      ST_HOLD: begin
        if (tmr_done) begin
          state_d = ST_REL;
        end
      end
      ST_REL: begin
        state_d  = ST_VERIFY;
        tmr_load = 1'b1;
        tmr_val  = READ_V;
      end
      ST_VERIFY: begin
        if (tmr_done) begin
          if (read_match) begin
            state_d = ST_REPORT;
            pass_d  = 1'b1;
          end else if (t_at_max) begin
            state_d = ST_REPORT;
            pass_d  = 1'b0;
          end else begin
            state_d  = ST_SETUP;
            tmr_load = 1'b1;
            tmr_val  = SETUP_V;
          end
        end
      end
      ST_REPORT: begin
        state_d = (!pass_q || last_q) ? ST_IDLE : ST_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
    end
  end

  // Request capture, enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '1;
      last_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
      last_q <= req_last;
    end
  end

  assign sts_valid  = (state_q == ST_REPORT);
  assign sts_addr   = addr_q;
  assign sts_pass   = pass_q;
  assign sts_pulses = t_cnt;

  // Strobe-length observer for the assertion below
  logic [TW:0] lo_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run_q <= '0;
    end else if (!mem_ce_n) begin
      lo_run_q <= lo_run_q + 1'b1;
    end else begin
      lo_run_q <= '0;
    end
  end

  // R2
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> (lo_run_q == (TW+1)'(PULSE_CYC)));

  // R3
  ce_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> ($stable(mem_addr) && $stable(mem_dout) && mem_dout_en && mem_oe_n));

  // R4
  read_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dout_en && mem_ce_n));

  // R4
  release_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dout_en));

  // R6
  fail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && !sts_pass) |-> (sts_pulses == CNT_W'(MAX_PULSES)));

  // R7
  skip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && sts_pulses == '0) |-> sts_pass);

  // R8
  sts_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |=> !sts_valid);

  // R9
  vpp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n || !mem_oe_n) |-> vpp_en);

endmodule

// File: tb/otp_burn_seq_tb.sv
module otp_burn_seq_tb;

  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;
  localparam int unsigned P  = 5;
  localparam int unsigned S  = 2;
  localparam int unsigned H  = 2;
  localparam int unsigned RD = 2;
  localparam int unsigned MX = 10;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          req_last;
  logic          sts_valid;
  logic [AW-1:0] sts_addr;
  logic          sts_pass;
  logic [3:0]    sts_pulses;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic          mem_dout_en;
  logic [DW-1:0] mem_din;
  logic          mem_ce_n;
  logic          mem_oe_n;
  logic          vpp_en;

  int nchk = 0;
  int nerr = 0;

  int          need_tab [16];
  int          applied  [16];
  logic [7:0]  burned   [16];

  otp_burn_seq #(
    .ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(P), .SETUP_CYC(S),
    .HOLD_CYC(H), .READ_CYC(RD), .MAX_PULSES(MX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
    .sts_valid(sts_valid), .sts_addr(sts_addr), .sts_pass(sts_pass),
    .sts_pulses(sts_pulses),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .vpp_en(vpp_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Memory model: a cell reads its burned value once it has taken enough strobes
  assign mem_din = (!mem_oe_n && mem_ce_n) ?
                   ((applied[mem_addr] >= need_tab[mem_addr]) ? burned[mem_addr] : 8'hFF) :
                   8'hFF;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pin monitor
  int   lo_run = 0;
  int   su_run = 0;
  int   ho_run = 0;
  bit   in_hold = 0;
  logic prev_ce = 1'b1;
  logic prev_den = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_dout = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) begin
        lo_run++;
        // R2 / R9: strobe carries OE high, bus driven, supply on
        chk(mem_oe_n && mem_dout_en && vpp_en, "R2", {mem_oe_n, mem_dout_en, vpp_en}, 7);
      end
      if (prev_ce && !mem_ce_n) begin
        chk(su_run >= S, "R3 setup", su_run, S);
      end
      if (!prev_ce && mem_ce_n) begin
        chk(lo_run == P, "R2 width", lo_run, P);
        lo_run = 0;
        applied[mem_addr]++;
        burned[mem_addr] = mem_dout;
        ho_run  = 0;
        in_hold = 1;
      end
      if (mem_dout_en && mem_ce_n)
        su_run = (mem_addr == prev_addr && mem_dout == prev_dout) ? su_run + 1 : 1;
      else
        su_run = 0;
      if (in_hold && mem_ce_n) begin
        if (mem_dout_en && mem_addr == prev_addr && mem_dout == prev_dout) begin
          ho_run++;
        end else begin
          chk(ho_run >= H, "R3 hold", ho_run, H);
          in_hold = 0;
        end
      end
      if (!mem_oe_n) begin
        chk(!prev_den && !mem_dout_en && mem_ce_n, "R4", {prev_den, mem_dout_en}, 0);
      end
      prev_ce   = mem_ce_n;
      prev_den  = mem_dout_en;
      prev_addr = mem_addr;
      prev_dout = mem_dout;
    end
  end

  task automatic run_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input int need,
                          input bit last, input bit exp_pass, input int exp_p, input string req);
    need_tab[a] = need;
    applied[a]  = 0;
    burned[a]   = 8'hFF;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_data  = d;
    req_last  = last;
    @(negedge clk);
    req_valid = 1'b0;
    // R9: supply on and request port closed during the byte
    chk(vpp_en == 1'b1, "R9 vpp on", vpp_en, 1);
    chk(req_ready == 1'b0, "R9 ready low", req_ready, 0);
    while (!sts_valid) @(negedge clk);
    chk(sts_addr == a, "R8 addr", sts_addr, a);
    chk(sts_pass == exp_pass, req, sts_pass, exp_pass);
    chk(sts_pulses == 4'(exp_p), req, sts_pulses, exp_p);
    chk(applied[a] == exp_p, {req, " pins"}, applied[a], exp_p);
    @(negedge clk);
    chk(sts_valid == 1'b0, "R8 single", sts_valid, 0);
    chk(vpp_en == !(last || !exp_pass), "R9 vpp after", vpp_en, !(last || !exp_pass));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      need_tab[i] = 0;
      applied[i]  = 0;
      burned[i]   = 8'hFF;
    end
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_data  = '0;
    req_last  = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(mem_ce_n && mem_oe_n && !mem_dout_en && !vpp_en && req_ready && !sts_valid,
        "R1 in reset", {mem_ce_n, mem_oe_n, mem_dout_en, vpp_en, req_ready, sts_valid}, 6'b110010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && !mem_dout_en && !vpp_en && req_ready && !sts_valid,
        "R1 after reset", {mem_ce_n, mem_oe_n, mem_dout_en, vpp_en, req_ready, sts_valid}, 6'b110010);

    // Batch 1: erased byte first, then cells needing 1..10 strobes, one more erased byte midway
    run_byte(4'd0, 8'hFF, 0, 1'b0, 1'b1, 0, "R7");
    for (int k = 1; k <= 10; k++) begin
      if (k == 6) run_byte(4'd11, 8'hFF, 0, 1'b0, 1'b1, 0, "R7");
      // R5 for k below the budget, R6 for k equal to it
      run_byte(4'(k), 8'hA5 ^ 8'(k), k, (k == 10), 1'b1, k, (k == 10) ? "R6 tie" : "R5");
    end

    // Batch 2: a cell that never verifies aborts the batch
    run_byte(4'd12, 8'h00, 11, 1'b0, 1'b0, MX, "R6 fail");
    repeat (3) @(negedge clk);
    chk(vpp_en == 1'b0 && req_ready, "R9 after abort", vpp_en, 0);

    // Batch 3: a new batch after the abort; a single-bit target passing on the third strobe
    run_byte(4'd13, 8'hFE, 3, 1'b0, 1'b1, 3, "R5");
    run_byte(4'd14, 8'h3C, 10, 1'b1, 1'b1, 10, "R6 tie");

    // Batch 4: lone erased byte flagged last
    run_byte(4'd15, 8'hFF, 0, 1'b1, 1'b1, 0, "R7");
    repeat (4) @(negedge clk);
    chk(vpp_en == 1'b0 && mem_ce_n && mem_oe_n, "R9 idle", vpp_en, 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual %0d expected %0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule